// File: doc/BRIEF.md
# Dual Watchdog Controller with Power-of-Two Millisecond Timeouts

The block holds two independent watchdog timers behind a small 8-bit register bus. The main timer guards the system: if software fails to service it before it runs out, it issues a one-cycle system-reset request and records a sticky flag, so that software can see after the restart why the restart happened. The auxiliary timer is a softer guard. When it runs out it drives a level alarm that the fan controller uses to switch the fans to full speed. It never causes a reset.

Each timer's period is 2^n milliseconds, with n taken from the low four bits of that timer's period register. Requests that are not powers of two are expected to have been rounded up by software. A shared prescaler turns the core clock into a 1 ms tick. Both timers are serviced through a single write-only service register, one bit per timer. Reading any address never returns the time that remains.

Top module: `wdt_pair`

## Requirements
- R1: After reset, both period registers read 0x0F, both control registers read 0x00, the cause register reads 0x00, and both outputs are low. The power-up period is the 30 s default rounded up to 2^15 ms. An enabled auxiliary timer left at that period raises its alarm after exactly 32768 ticks.
- R2: Address 1 (main period) and address 3 (auxiliary period) store all 8 written bits and read them back unchanged. Only bits [3:0] select the exponent n, and n = 0 gives a one-tick period.
- R3: A 1 ms tick occurs once every CLK_PER_MS core cycles. The prescaler runs freely from reset, and timers only count on ticks.
- R4: Bit 0 of address 2 enables the main timer, and a 0-to-1 write of that bit reloads it with 2^n ticks. When the count reaches zero, sys_rst_req_o is high for exactly one cycle, in the cycle after the edge that consumed the final tick.
- R5: A write to address 0 with bit 0 set reloads the main timer, and a write with bit 1 set reloads the auxiliary timer. Servicing one timer does not reload the other. Address 0 always reads 0x00.
- R6: Bit 4 of address 4 enables the auxiliary timer, and a 0-to-1 write of that bit reloads it. On expiry, fan_full_o rises and stays high until the auxiliary timer is serviced or disabled. Auxiliary expiry never drives sys_rst_req_o.
- R7: Bit 6 of address 5 is set on the cycle after each main reset request and stays set. Writing 1 to that bit clears it, and writing 0 has no effect. If a set and a clear arrive in the same cycle, the set wins. All other bits of address 5 read 0.
- R8: After expiry a timer stops counting, and the main timer issues no further requests until it is reloaded.
- R9: Clearing a timer's enable bit freezes its count and clears its alarm one cycle later. Re-enabling it reloads the full period, whatever count had been left.
- R10: A new exponent written while a timer is running takes effect only at that timer's next reload.
- R11: Addresses 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe, sampled on the rising clock edge |
| addr_i | input | 3 | Register address for both writes and reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| sys_rst_req_o | output | 1 | One-cycle system-reset request from the main timer |
| fan_full_o | output | 1 | Level alarm from the auxiliary timer that forces the fans to full speed |

## Verification
The bench runs the timers against the free-running prescaler, so expiry windows are measured from an arbitrary tick phase. Those windows expose an off-by-one in the reload or a counter that restarts the prescaler. Several cases catch wrong cross-coupling:
- Servicing only the auxiliary bit while the main timer runs must still let the main timer expire.
- An auxiliary alarm must never pulse the reset line.
- A mid-run exponent write must leave the current period alone.

A design that keeps the reset request asserted, re-fires after expiry, loses the sticky cause bit when 0 is written to it, or clears it when it should hold would show up as a mismatch against the cycle model. The n = 0 and n = 15 boundary periods, the pause caused by disabling, and the full reload on re-enable are each checked against exact cycle windows.

// File: rtl/wdt_pair_pkg.sv
package wdt_pair_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_WDT = 2;

  localparam logic [ADDR_W-1:0] A_KICK     = 3'd0;
  localparam logic [ADDR_W-1:0] A_MAIN_PER = 3'd1;
  localparam logic [ADDR_W-1:0] A_MAIN_CTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_AUX_PER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_AUX_CTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAUSE    = 3'd5;

  localparam int unsigned MAIN_EN_BIT = 0;
  localparam int unsigned AUX_EN_BIT  = 4;
  localparam int unsigned CAUSE_BIT   = 6;

  function automatic int unsigned en_bit_of(input int unsigned idx);
    return (idx == 0) ? MAIN_EN_BIT : AUX_EN_BIT;
  endfunction

  function automatic logic [ADDR_W-1:0] per_addr_of(input int unsigned idx);
    return (idx == 0) ? A_MAIN_PER : A_AUX_PER;
  endfunction

  function automatic logic [ADDR_W-1:0] ctl_addr_of(input int unsigned idx);
    return (idx == 0) ? A_MAIN_CTL : A_AUX_CTL;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pair_pkg::*;
#(
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned DEF_EXP = 15
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic                            fire_main_i,
  output logic [NUM_WDT-1:0][EXP_W-1:0]   exp_o,
  output logic [NUM_WDT-1:0]              en_o,
  output logic [NUM_WDT-1:0]              load_o,
  output logic                            cause_o
);
  localparam logic [DATA_W-1:0] PER_RST = DATA_W'(DEF_EXP);

  logic [NUM_WDT-1:0][DATA_W-1:0] per_q;
  logic [NUM_WDT-1:0][DATA_W-1:0] ctl_q;
  logic                           cause_q;
  logic                           kick_wr;
  logic                           cause_clr;

  assign kick_wr   = we_i && (addr_i == A_KICK);
  assign cause_clr = we_i && (addr_i == A_CAUSE) && wdata_i[CAUSE_BIT];

  for (genvar g = 0; g < NUM_WDT; g++) begin : g_inst
    localparam int unsigned      EN_BIT = en_bit_of(g);
    localparam logic [ADDR_W-1:0] PER_A = per_addr_of(g);
    localparam logic [ADDR_W-1:0] CTL_A = ctl_addr_of(g);

    logic wr_per, wr_ctl;
    assign wr_per = we_i && (addr_i == PER_A);
    assign wr_ctl = we_i && (addr_i == CTL_A);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        per_q[g] <= PER_RST;
        ctl_q[g] <= '0;
      end else begin
        if (wr_per) per_q[g] <= wdata_i;
        if (wr_ctl) ctl_q[g] <= wdata_i;
      end
    end

    assign en_o[g]   = ctl_q[g][EN_BIT];
    assign exp_o[g]  = per_q[g][EXP_W-1:0];
    // reload on service bit or on enable 0->1
    assign load_o[g] = (kick_wr && wdata_i[g]) ||
                       (wr_ctl && wdata_i[EN_BIT] && !ctl_q[g][EN_BIT]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= 1'b0;
    else         cause_q <= (cause_q && !cause_clr) || fire_main_i;
  end

  assign cause_o = cause_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MAIN_PER: rdata_o = per_q[0];
      A_MAIN_CTL: rdata_o = ctl_q[0];
      A_AUX_PER:  rdata_o = per_q[1];
      A_AUX_CTL:  rdata_o = ctl_q[1];
      A_CAUSE:    rdata_o = DATA_W'(cause_q) << CAUSE_BIT;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned EXP_W = 4,
  parameter bit          PULSE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             alarm_o
);
  localparam int unsigned CNT_W = 1 << EXP_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;
  logic             step;
  logic             hit;

  assign step = en_i && tick_i && !expired_q && (cnt_q != '0);
  assign hit  = !load_i && step && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= ONE << exp_i;
      expired_q <= 1'b0;
    end else if (!en_i) begin
      expired_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) expired_q <= 1'b1;
    end
  end

  if (PULSE) begin : g_pulse
    logic fire_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fire_q <= 1'b0;
      else         fire_q <= hit;
    end
    assign alarm_o = fire_q;
  end else begin : g_level
    assign alarm_o = expired_q;
  end
endmodule

// File: rtl/wdt_pair.sv
module wdt_pair
  import wdt_pair_pkg::*;
#(
  parameter int unsigned CLK_PER_MS         = 50000,
  parameter int unsigned EXP_W              = 4,
  parameter int unsigned DEFAULT_TIMEOUT_MS = 30000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sys_rst_req_o,
  output logic              fan_full_o
);
  localparam int unsigned MAX_EXP = (1 << EXP_W) - 1;
  localparam int unsigned RAW_EXP = $clog2(DEFAULT_TIMEOUT_MS);
  localparam int unsigned DEF_EXP = (RAW_EXP > MAX_EXP) ? MAX_EXP : RAW_EXP;

  logic                          tick;
  logic [NUM_WDT-1:0][EXP_W-1:0] wdt_exp;
  logic [NUM_WDT-1:0]            wdt_en;
  logic [NUM_WDT-1:0]            wdt_load;
  logic [NUM_WDT-1:0]            wdt_alarm;
  logic                          cause_flag;

  wdt_prescaler #(.DIV(CLK_PER_MS)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  wdt_regs #(.EXP_W(EXP_W), .DEF_EXP(DEF_EXP)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .fire_main_i (wdt_alarm[0]),
    .exp_o       (wdt_exp),
    .en_o        (wdt_en),
    .load_o      (wdt_load),
    .cause_o     (cause_flag)
  );

  // instance 0 pulses a reset request, instance 1 holds a level alarm
  for (genvar g = 0; g < NUM_WDT; g++) begin : g_wdt
    wdt_countdown #(.EXP_W(EXP_W), .PULSE(g == 0)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .en_i    (wdt_en[g]),
      .load_i  (wdt_load[g]),
      .exp_i   (wdt_exp[g]),
      .alarm_o (wdt_alarm[g])
    );
  end

  assign sys_rst_req_o = wdt_alarm[0];
  assign fan_full_o    = wdt_alarm[1];
endmodule

// File: rtl/wdt_pair_checker.sv
module wdt_pair_checker
  import wdt_pair_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sys_rst_req_o,
  input logic              fan_full_o,
  input logic              main_en_i,
  input logic              aux_en_i,
  input logic              cause_i
);
  a_r4_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);

  a_r4_pulse_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(main_en_i));

  a_r7_cause_follows_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> cause_i);

  a_r7_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i && !(we_i && addr_i == A_CAUSE && wdata_i[CAUSE_BIT])) |=> cause_i);

  a_r6_fan_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fan_full_o |-> $past(aux_en_i));

  a_r5_kick_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_KICK) |-> (rdata_o == '0));

  a_r11_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > A_CAUSE) |-> (rdata_o == '0));
endmodule

bind wdt_pair wdt_pair_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .sys_rst_req_o (sys_rst_req_o),
  .fan_full_o    (fan_full_o),
  .main_en_i     (wdt_en[0]),
  .aux_en_i      (wdt_en[1]),
  .cause_i       (cause_flag)
);

// File: tb/wdt_pair_test.sv
module wdt_pair_test;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata_o;
  logic       sys_rst_req_o;
  logic       fan_full_o;

  int n_chk = 0;
  int n_fail = 0;
  int n_rst = 0;
  bit run = 1'b0;

  always #10 clk = ~clk;

  wdt_pair #(.CLK_PER_MS(DIV)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .we_i          (we),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .rdata_o       (rdata_o),
    .sys_rst_req_o (sys_rst_req_o),
    .fan_full_o    (fan_full_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_per [2] = '{8'h0F, 8'h0F};
  logic [7:0] m_ctl [2] = '{8'h00, 8'h00};
  int         m_cnt [2] = '{0, 0};
  bit         m_exp [2] = '{1'b0, 1'b0};
  bit         m_fire = 1'b0;
  bit         m_cause = 1'b0;
  int         m_presc = 0;

  function automatic int en_pos(input int i);
    return (i == 0) ? 0 : 4;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_per = '{8'h0F, 8'h0F};
      m_ctl = '{8'h00, 8'h00};
      m_cnt = '{0, 0};
      m_exp = '{1'b0, 1'b0};
      m_fire = 1'b0;
      m_cause = 1'b0;
      m_presc = 0;
    end else begin
      bit tick;
      bit new_fire;
      tick = (m_presc == DIV - 1);
      new_fire = 1'b0;
      for (int i = 0; i < 2; i++) begin
        bit en, load;
        en = m_ctl[i][en_pos(i)];
        load = (we && addr == 3'd0 && wdata[i]) ||
               (we && addr == ((i == 0) ? 3'd2 : 3'd4) && wdata[en_pos(i)] && !en);
        if (load) begin
          m_cnt[i] = 1 << m_per[i][3:0];
          m_exp[i] = 1'b0;
        end else if (!en) begin
          m_exp[i] = 1'b0;
        end else if (tick && !m_exp[i] && m_cnt[i] != 0) begin
          m_cnt[i]--;
          if (m_cnt[i] == 0) begin
            m_exp[i] = 1'b1;
            if (i == 0) new_fire = 1'b1;
          end
        end
      end
      if (we && addr == 3'd5 && wdata[6]) m_cause = 1'b0;
      if (m_fire) m_cause = 1'b1;
      m_fire = new_fire;
      if (we && addr == 3'd1) m_per[0] = wdata;
      if (we && addr == 3'd2) m_ctl[0] = wdata;
      if (we && addr == 3'd3) m_per[1] = wdata;
      if (we && addr == 3'd4) m_ctl[1] = wdata;
      m_presc = tick ? 0 : m_presc + 1;
    end
  end

  function automatic int exp_rd(input logic [2:0] a);
    case (a)
      3'd1: return m_per[0];
      3'd2: return m_ctl[0];
      3'd3: return m_per[1];
      3'd4: return m_ctl[1];
      3'd5: return m_cause ? 8'h40 : 8'h00;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd1, 3'd3: return "R2";
      3'd2, 3'd4: return "R4";
      3'd5: return "R7";
      default: return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (sys_rst_req_o) n_rst++;
    if (run) begin
      chk(sys_rst_req_o === m_fire, "R4", sys_rst_req_o, m_fire);
      chk(fan_full_o === m_exp[1], "R6", fan_full_o, m_exp[1]);
      chk(rdata_o === 8'(exp_rd(addr)), req_of(addr), rdata_o, exp_rd(addr));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
    @(posedge clk); #2;
    addr = a;
    @(negedge clk);
    chk(rdata_o === 8'(exp), req, rdata_o, exp);
  endtask

  task automatic chk_fan(input bit exp, input string req);
    @(negedge clk);
    chk(fan_full_o === exp, req, fan_full_o, exp);
  endtask

  task automatic wait_rst(input int maxk, output int t, output int hits);
    t = -1;
    hits = 0;
    for (int k = 1; k <= maxk; k++) begin
      @(negedge clk);
      if (sys_rst_req_o) begin
        hits++;
        if (t < 0) t = k;
      end
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    rst_ni = 1'b1;
  endtask

  task automatic reset_reads();
    rd_chk(3'd1, 8'h0F, "R1");
    rd_chk(3'd2, 8'h00, "R1");
    rd_chk(3'd3, 8'h0F, "R1");
    rd_chk(3'd4, 8'h00, "R1");
    rd_chk(3'd5, 8'h00, "R1");
    chk(sys_rst_req_o === 1'b0, "R1", sys_rst_req_o, 0);
    chk(fan_full_o === 1'b0, "R1", fan_full_o, 0);
  endtask

  function automatic int lo_k(input int ticks);
    return DIV * (ticks - 1) + 2;
  endfunction

  function automatic int hi_k(input int ticks);
    return DIV * ticks + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t, h, n0;
    repeat (3) @(posedge clk);
    #2;
    rst_ni = 1'b1;
    run = 1'b1;

    // R1, R11, R5 reset state and idle addresses
    reset_reads();
    rd_chk(3'd0, 8'h00, "R5");
    rd_chk(3'd6, 8'h00, "R11");
    rd_chk(3'd7, 8'h00, "R11");

    // R2 full readback, exponent 2
    wr(3'd1, 8'hA2);
    rd_chk(3'd1, 8'hA2, "R2");

    // R4 R3 enable and expiry window
    wr(3'd2, 8'h01);
    wait_rst(20, t, h);
    chk(t >= lo_k(4) && t <= hi_k(4), "R4", t, lo_k(4));
    chk(h == 1, "R4", h, 1);
    n0 = n_rst;
    idle(60);
    chk(n_rst == n0, "R8", n_rst, n0);
    rd_chk(3'd5, 8'h40, "R7");

    // R7 write-0 no effect, write-1 clears
    wr(3'd5, 8'hBF);
    rd_chk(3'd5, 8'h40, "R7");
    wr(3'd5, 8'h40);
    rd_chk(3'd5, 8'h00, "R7");

    // R5 periodic service prevents expiry
    n0 = n_rst;
    wr(3'd0, 8'h01);
    repeat (10) begin
      idle(6);
      wr(3'd0, 8'h01);
    end
    chk(n_rst == n0, "R5", n_rst, n0);
    wait_rst(20, t, h);
    chk(h == 1, "R5", h, 1);

    // R5 auxiliary service does not reload main
    wr(3'd0, 8'h01);
    repeat (3) wr(3'd0, 8'h02);
    wait_rst(10, t, h);
    chk(h == 1, "R5", h, 1);

    // R6 auxiliary alarm
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h01);
    wr(3'd4, 8'h10);
    n0 = n_rst;
    idle(8);
    chk_fan(1'b1, "R6");
    idle(20);
    chk_fan(1'b1, "R6");
    chk(n_rst == n0, "R6", n_rst, n0);
    rd_chk(3'd4, 8'h10, "R6");
    wr(3'd0, 8'h02);
    chk_fan(1'b0, "R6");
    idle(10);
    chk_fan(1'b1, "R6");

    // R9 disable clears alarm
    wr(3'd4, 8'h00);
    idle(1);
    chk_fan(1'b0, "R9");
    idle(20);
    chk_fan(1'b0, "R9");

    // R10 exponent change during run
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h03);
    wait_rst(8, t, h);
    chk(t >= 3 && t <= 5, "R10", t, 3);
    chk(h == 1, "R10", h, 1);
    rd_chk(3'd1, 8'h03, "R2");

    // R9 re-enable reloads full period
    wr(3'd2, 8'h00);
    wr(3'd2, 8'h01);
    idle(10);
    wr(3'd2, 8'h00);
    idle(5);
    wr(3'd2, 8'h01);
    wait_rst(30, t, h);
    chk(t >= lo_k(8) && t <= hi_k(8), "R9", t, lo_k(8));

    // R2 exponent zero
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd2, 8'h01);
    wait_rst(6, t, h);
    chk(t >= lo_k(1) && t <= hi_k(1), "R2", t, lo_k(1));
    chk(h == 1, "R3", h, 1);

    // R1 default period after a fresh reset
    do_reset();
    reset_reads();
    wr(3'd4, 8'h10);
    idle(DIV * 32767);
    chk_fan(1'b0, "R1");
    idle(4);
    chk_fan(1'b1, "R1");

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule